// File: doc/BRIEF.md
# Post-Idle First Character Detector

This block watches a serial transmit line that rests high between characters. It raises a single-cycle flag one character time after a start bit, but only for a start bit that ends a quiet spell. The line must have stayed high for a minimum number of clock cycles before that start bit. The first character of each burst is flagged. The characters that follow it in the same burst are not, because every low bit clears the quiet-time measurement.

The block does not sample data bits, check framing or generate a baud rate. It only times line activity. Both the quiet interval and the character duration are counted in clock cycles and set through parameters. A typical use is to mark the first byte a transmitter sends after a pause, for a trace unit or a debug trigger.

Top module: `uart_idle_byte_det`

## Requirements
- R1: While reset is asserted and at the first clock edge after it, `byte_after_idle_o` is 0, the quiet-time measurement starts at zero, and no character wait is pending.
- R2: The line counts as quiet once `line_i` has been sampled high at IDLE_CYCLES consecutive rising clock edges. A single low sample clears the measurement.
- R3: A start edge is a rising clock edge that samples `line_i` low when the previous edge sampled it high. It is accepted only if the line was quiet at that moment. A run of exactly IDLE_CYCLES high samples before the edge is enough; a run of IDLE_CYCLES-1 is not.
- R4: Suppose a start edge is accepted at clock edge k. Then `byte_after_idle_o` is 1 for the cycle that follows edge k+CHAR_CYCLES.
- R5: From the accepting edge up to and including edge k+CHAR_CYCLES, further start edges are ignored. They neither schedule nor delay a pulse.
- R6: In a back-to-back burst, the characters after the first produce no pulse, because their low bits keep the line from counting as quiet.
- R7: After reset, the line is not quiet until IDLE_CYCLES high samples have been seen. A start edge that comes sooner produces no pulse, even if the line was high throughout reset.
- R8: The quiet-time measurement saturates rather than wrapping. A start edge after an arbitrarily long high period is accepted.
- R9: `byte_after_idle_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial line, high when idle, already synchronous to clk_i |
| byte_after_idle_o | output | 1 | One-cycle pulse one character time after an accepted start edge |

## Verification
The hardest situation to reach is a start edge that lands exactly on the quiet-threshold boundary, or on the last cycle of a pending character wait. An off-by-one in either counter only shows up there. The stimulus builds the line as exact runs of high and low cycles: runs of exactly IDLE_CYCLES and IDLE_CYCLES-1, and a burst whose falling edges fall inside the wait. A per-cycle reference model pushes the expected pulse cycle into a queue, and the monitor pops each entry as the pulse appears. A saturation run holds the line high far past the width of the quiet counter.

// File: rtl/uid_pkg.sv
package uid_pkg;
  typedef enum logic {
    CT_ARMED = 1'b0,
    CT_WAIT  = 1'b1
  } ct_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/uid_idle_timer.sv
module uid_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic idle_o
);
  localparam int unsigned IW = uid_pkg::cnt_width(IDLE_CYCLES);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYCLES);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!line_i)           cnt_q <= '0;
    else if (cnt_q != IDLE_MAX) cnt_q <= cnt_q + 1'b1;  // saturate at threshold
  end

  assign idle_o = (cnt_q == IDLE_MAX);
endmodule

// File: rtl/uid_fall_det.sv
module uid_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= line_i;
  end

  assign fall_o = prev_q & ~line_i;
endmodule

// File: rtl/uid_char_timer.sv
module uid_char_timer #(
  parameter int unsigned CHAR_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  import uid_pkg::*;

  localparam int unsigned CW = cnt_width(CHAR_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CHAR_CYCLES - 1);

  ct_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CT_ARMED;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CT_ARMED: if (start_i) begin
          state_q <= CT_WAIT;
          cnt_q   <= LOAD;
        end
        CT_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= CT_ARMED;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= CT_ARMED;
      endcase
    end
  end

  assign busy_o = (state_q == CT_WAIT);
  assign done_o = done_q;
endmodule

// File: rtl/uart_idle_byte_det.sv
module uart_idle_byte_det #(
  parameter int unsigned IDLE_CYCLES = 100,
  parameter int unsigned CHAR_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic byte_after_idle_o
);
  logic idle;
  logic fall;
  logic busy;
  logic start;

  uid_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) idle_tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .idle_o (idle)
  );

  uid_fall_det fall_det_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .fall_o (fall)
  );

  // edges during a pending wait are dropped
  assign start = fall & idle & ~busy;

  uid_char_timer #(.CHAR_CYCLES(CHAR_CYCLES)) char_tmr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (byte_after_idle_o)
  );
endmodule

// File: rtl/uid_checker.sv
module uid_checker #(
  parameter int unsigned IDLE_CYCLES = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic idle,
  input logic busy,
  input logic pulse
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!line_i)              run_q <= '0;
    else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1;
  end

  assert_idle_needs_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> (run_q >= IDLE_CYCLES));
  assert_low_clears_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !idle);
  assert_start_qualified_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(idle) && !$past(line_i)));
  assert_wait_ends_with_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (busy || pulse));
  assert_pulse_after_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |-> $past(busy));
  assert_pulse_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !pulse);
endmodule

bind uart_idle_byte_det uid_checker #(.IDLE_CYCLES(IDLE_CYCLES)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .line_i (line_i),
  .idle   (idle),
  .busy   (busy),
  .pulse  (byte_after_idle_o)
);

// File: tb/uart_idle_byte_det_tb_top.sv
module uart_idle_byte_det_tb_top;
  localparam int unsigned IDLE = 20;
  localparam int unsigned CHAR = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  uart_idle_byte_det #(.IDLE_CYCLES(IDLE), .CHAR_CYCLES(CHAR)) dut_i (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .line_i            (line),
    .byte_after_idle_o (pulse)
  );

  // reference model: pushes expected pulse cycle (R2..R8)
  int  m_run = 0;
  bit  m_prev = 1'b1;
  int  m_deadline = -1;
  always @(posedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (!line) begin
        if (m_prev && m_run >= IDLE && cyc > m_deadline) begin
          m_deadline = cyc + CHAR;
          exp_q.push_back(cyc + CHAR);
        end
        m_run = 0;
      end else begin
        m_run = m_run + 1;
      end
      m_prev = line;
    end
  end

  // monitor
  bit prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; fails++;
        $display("FAIL R4: missed pulse, actual none, expected cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (pulse) begin
        pulses++;
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) void'(exp_q.pop_front());
        else begin
          fails++;
          $display("FAIL R4: pulse at cycle %0d, expected %0d", cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
        checks++;
        if (prev_pulse) begin
          fails++;
          $display("FAIL R9: pulse width actual >1, expected 1 at cycle %0d", cyc);
        end
      end
      prev_pulse = pulse;
    end
  end

  task automatic hold(input bit v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulses(input string req, input int base, input int exp);
    checks++;
    if (pulses - base != exp) begin
      fails++;
      $display("FAIL %s: pulse count actual %0d, expected %0d", req, pulses - base, exp);
    end
  endtask

  int base;

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (pulse !== 1'b0) begin
      fails++; $display("FAIL R1: output in reset actual %b, expected 0", pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 after release
    if (pulse !== 1'b0) begin
      fails++; $display("FAIL R1: output after reset actual %b, expected 0", pulse);
    end

    // R7: short high after reset, then fall -> nothing
    base = pulses;
    hold(1, 5); hold(0, 2); hold(1, CHAR + 5);
    expect_pulses("R7", base, 0);

    // R2/R4: long idle then one byte
    base = pulses;
    hold(1, 30); hold(0, 3); hold(1, CHAR + 5);
    expect_pulses("R4", base, 1);

    // R3 boundary: exactly IDLE highs accepted
    base = pulses;
    hold(0, 2); hold(1, IDLE); hold(0, 1); hold(1, CHAR + 5);
    expect_pulses("R3", base, 1);

    // R3 boundary: IDLE-1 highs rejected
    base = pulses;
    hold(0, 2); hold(1, IDLE - 1); hold(0, 1); hold(1, CHAR + 5);
    expect_pulses("R3", base, 0);

    // R5/R6: burst, falls inside window ignored, later bytes not idle
    base = pulses;
    hold(1, IDLE + 5);
    hold(0, 2); hold(1, 2); hold(0, 2); hold(1, 2); hold(0, 1); hold(1, 1);
    expect_pulses("R5", base, 0);
    hold(0, 2); hold(1, 3); hold(0, 2); hold(1, 3); hold(0, 2);
    hold(1, CHAR + 5);
    expect_pulses("R6", base, 1);

    // R5: fall exactly on the last wait edge is ignored
    base = pulses;
    hold(1, IDLE + 2); hold(0, 1); hold(1, CHAR - 1); hold(0, 1); hold(1, CHAR + 5);
    expect_pulses("R5", base, 1);

    // R2: rising edge and steady high alone never fire
    base = pulses;
    hold(0, 4); hold(1, IDLE + 40);
    expect_pulses("R2", base, 0);

    // R8: long high well past counter width
    base = pulses;
    hold(1, 300); hold(0, 2); hold(1, CHAR + 5);
    expect_pulses("R8", base, 1);

    checks++;  // scoreboard drained
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R4: pending expected actual %0d, expected 0", exp_q.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule